// File: doc/BRIEF.md
# Packet Buffer Allocation Unit

This block keeps track of a small pool of equally sized packet buffers inside a network controller. It hands out buffer numbers, takes them back, and keeps three ordered lists of buffer numbers: packets waiting to be sent, packets already sent that the host has not yet collected, and packets received. The packet memory, the serialiser that sends frames and the host bus decoder sit outside the block. They talk to it through a byte-wide host write port and two request/acknowledge pairs.

The host writes one of four registers per clock. It can issue a command, set the packet-number register, acknowledge interrupt bits, or set the interrupt mask. A command is the top three bits of its byte and selects one of eight operations. The serialiser asks for the head of the send list to be retired, and the receive side asks for a fresh buffer. These sideband requests are taken only in cycles without a host write, and a send retirement wins over a receive allocation. If a send allocation fails because the pool is full, it stays pending. It is retried whenever any buffer is released.

Top module: `pbuf_alloc_unit`

## Requirements
- R1: After reset the three lists are empty, no buffer is allocated, the allocation result is 0, the interrupt level is 0x04, the interrupt mask is 0 and `irq` is low.
- R2: Command 1 (bits 7:5 of the command byte) takes the lowest free buffer index, places it in the allocation result and sets level bit 3 (0x08).
- R3: Command 1 with all buffers in use gives the allocation result 0x80 and leaves level bit 3 clear.
- R4: While the allocation result is 0x80, any buffer release in the same cycle re-runs the allocation, which sets the result to that freed index and sets level bit 3.
- R5: The heads of the sent list and the receive list read 0x80 when the list is empty.
- R6: Command 6 appends the low index bits of the packet-number register to the send list if it has room. Retiring the send head frees its buffer when `auto_release` is high. Otherwise it appends the number to the sent list, kept in first-in first-out order, and the buffer stays allocated.
- R7: A receive request takes the lowest free buffer, returns its number, appends it to the receive list and sets level bit 0 (0x01). With the pool full it returns `rx_fail` high, number 0x80, and changes nothing.
- R8: Command 3 drops the receive head and command 4 drops it and frees its buffer. Afterwards level bit 0 is set if entries remain and cleared if the list is empty.
- R9: Level bit 2 (0x04) is held set while the send list is empty, and level bit 1 (0x02) while the sent list is non-empty. `irq` is high exactly when the level ANDed with the mask is non-zero.
- R10: An acknowledge write clears only the level bits in (data AND 0xD6), so bits 3 and 0 survive. When data bit 1 is set, it also drops the sent-list head.
- R11: Command 2 frees every buffer, empties all three lists and sets the allocation result to 0. Command 7 empties the send and sent lists only.
- R12: A sideband request in a cycle with a host write is not served in that cycle. It is served in a later cycle.
- R13: `alloc_count` equals the number of allocated buffers and `pool_size` reads the pool size (4).
- R14: Command 5 frees the buffer named by the low index bits of the packet-number register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Register select: 0 command, 1 packet number, 2 acknowledge, 3 mask |
| host_wdata | input | 8 | Host write byte |
| auto_release | input | 1 | Free buffers as soon as they are sent |
| tx_req | input | 1 | Serialiser asks to retire the send head |
| tx_ack | output | 1 | One-cycle pulse: send head retired |
| txq_valid | output | 1 | Send list non-empty |
| txq_num | output | 8 | Send list head buffer number |
| rx_req | input | 1 | Receive side asks for a buffer |
| rx_ack | output | 1 | One-cycle pulse: receive request served |
| rx_fail | output | 1 | Served receive request found the pool full |
| rx_num | output | 8 | Buffer number granted (0x80 on failure) |
| tx_result | output | 8 | Send allocation result |
| pkt_num | output | 8 | Packet-number register |
| done_head | output | 8 | Sent list head, 0x80 when empty |
| rx_head | output | 8 | Receive list head, 0x80 when empty |
| alloc_count | output | 3 | Number of allocated buffers |
| pool_size | output | 3 | Number of buffers in the pool |
| irq_level | output | 8 | Interrupt level bits |
| irq_mask | output | 8 | Interrupt mask bits |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a pending send allocation that is settled by a release. The pool must be completely full, a send allocation must already have failed, and a release must then arrive. The bench fills the pool with four allocations and issues a fifth that fails. It then frees each index in turn by packet number, forcing a fresh failure before each release, so the retry is seen to land on every index. A second hard case is a host write and a receive request in the same cycle. The bench raises both on one edge and confirms the grant appears only one cycle later.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;

   typedef enum logic [2:0] {
      OP_NOP       = 3'd0,
      OP_TX_ALLOC  = 3'd1,
      OP_RESET     = 3'd2,
      OP_RX_DROP   = 3'd3,
      OP_RX_FREE   = 3'd4,
      OP_FREE_PNUM = 3'd5,
      OP_TX_QUEUE  = 3'd6,
      OP_TX_FLUSH  = 3'd7
   } op_e;

   typedef enum logic [1:0] {
      SEL_CMD  = 2'd0,
      SEL_PNUM = 2'd1,
      SEL_ACK  = 2'd2,
      SEL_MASK = 2'd3
   } sel_e;

   localparam int IRQ_RCV     = 0;
   localparam int IRQ_TXDONE  = 1;
   localparam int IRQ_TXEMPTY = 2;
   localparam int IRQ_ALLOC   = 3;

   localparam logic [7:0] ACK_CLEARABLE = 8'hD6;
   localparam logic [7:0] NONE_CODE     = 8'h80;
   localparam logic [7:0] LEVEL_RESET   = 8'h04;

endpackage

// File: rtl/pbuf_pool.sv
module pbuf_pool #(
   parameter int NUM_BUFS = 4,
   localparam int IW = $clog2(NUM_BUFS),
   localparam int CW = $clog2(NUM_BUFS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          rel_en,
   input  logic [IW-1:0] rel_idx,
   input  logic          alloc_en,
   output logic          alloc_ok,
   output logic [IW-1:0] alloc_idx,
   output logic          full,
   output logic [CW-1:0] count
);

   logic [NUM_BUFS-1:0] used_q, used_d, rel_vec, avail, grant_vec;

   // release is applied before the allocation search of the same cycle
   always_comb begin
      rel_vec = '0;
      for (int i = 0; i < NUM_BUFS; i++)
         if (rel_en && rel_idx == IW'(i)) rel_vec[i] = 1'b1;
      avail = used_q & ~rel_vec;
   end

   // lowest free index wins
   always_comb begin
      alloc_ok  = 1'b0;
      alloc_idx = '0;
      for (int i = NUM_BUFS - 1; i >= 0; i--) begin
         if (!avail[i]) begin
            alloc_ok  = 1'b1;
            alloc_idx = IW'(i);
         end
      end
   end

   always_comb begin
      grant_vec = '0;
      for (int i = 0; i < NUM_BUFS; i++)
         if (alloc_en && alloc_ok && alloc_idx == IW'(i)) grant_vec[i] = 1'b1;
      used_d = clear ? '0 : (avail | grant_vec);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) used_q <= '0;
      else        used_q <= used_d;
   end

   always_comb begin
      count = '0;
      for (int i = 0; i < NUM_BUFS; i++)
         count = count + CW'(used_q[i]);
   end

   assign full = &used_q;

   assert_grant_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && alloc_ok && !clear) |=> used_q[$past(alloc_idx)]);

endmodule

// File: rtl/pbuf_queue.sv
module pbuf_queue #(
   parameter int DEPTH = 4,
   parameter int W     = 2,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic [CW-1:0] count_next,
   output logic          empty,
   output logic          full
);

   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   logic [DEPTH*W-1:0] mem_q, mem_d;
   logic [CW-1:0]      cnt_q, wr_pos;
   logic               pop_e, push_e;

   assign empty  = (cnt_q == '0);
   assign full   = (cnt_q == DEPTH_C);
   assign pop_e  = pop && !empty;
   assign push_e = push && (!full || pop_e);
   assign wr_pos = pop_e ? cnt_q - 1'b1 : cnt_q;

   // entries shift toward slot 0 on a pop; slot 0 is the head
   always_comb begin
      mem_d = pop_e ? (mem_q >> W) : mem_q;
      if (push_e) mem_d[wr_pos*W +: W] = din;
      if (clear)
         count_next = '0;
      else
         count_next = cnt_q + {{(CW-1){1'b0}}, push_e} - {{(CW-1){1'b0}}, pop_e};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_q <= '0;
         cnt_q <= '0;
      end else begin
         mem_q <= mem_d;
         cnt_q <= count_next;
      end
   end

   assign head  = mem_q[W-1:0];
   assign count = cnt_q;

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop));

endmodule

// File: rtl/pbuf_alloc_unit.sv
module pbuf_alloc_unit
   import pbuf_pkg::*;
#(
   parameter int NUM_BUFS = 4,
   localparam int IW = $clog2(NUM_BUFS),
   localparam int CW = $clog2(NUM_BUFS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic [1:0]    host_sel,
   input  logic [7:0]    host_wdata,
   input  logic          auto_release,
   input  logic          tx_req,
   output logic          tx_ack,
   output logic          txq_valid,
   output logic [7:0]    txq_num,
   input  logic          rx_req,
   output logic          rx_ack,
   output logic          rx_fail,
   output logic [7:0]    rx_num,
   output logic [7:0]    tx_result,
   output logic [7:0]    pkt_num,
   output logic [7:0]    done_head,
   output logic [7:0]    rx_head,
   output logic [CW-1:0] alloc_count,
   output logic [CW-1:0] pool_size,
   output logic [7:0]    irq_level,
   output logic [7:0]    irq_mask,
   output logic          irq
);

   localparam logic [CW-1:0] ONE_C = CW'(1);

   if (NUM_BUFS < 2 || NUM_BUFS > 128 || (NUM_BUFS & (NUM_BUFS - 1)) != 0) begin : g_bad_cfg
      $error("pbuf_alloc_unit: NUM_BUFS must be a power of two from 2 to 128");
   end

   function automatic logic [7:0] widen(input logic [IW-1:0] idx);
      return {{(8-IW){1'b0}}, idx};
   endfunction

   // ---------------- decode ----------------
   op_e  op;
   logic host_cmd, host_ack, host_mask, host_pnum;
   logic tx_serve, rx_serve;
   logic tx_ack_q, rx_ack_q, rx_fail_q;
   logic [7:0] rx_num_q, txres_q, pnum_q, lvl_q, lvl_d, imask_q;

   assign op        = op_e'(host_wdata[7:5]);
   assign host_cmd  = host_we && host_sel == SEL_CMD;
   assign host_pnum = host_we && host_sel == SEL_PNUM;
   assign host_ack  = host_we && host_sel == SEL_ACK;
   assign host_mask = host_we && host_sel == SEL_MASK;

   // queue handles
   logic [IW-1:0] txq_h, dq_h, rxq_h;
   logic [CW-1:0] txq_cnt, txq_nxt, dq_cnt, dq_nxt, rxq_cnt, rxq_nxt;
   logic          txq_empty, txq_full, dq_empty, dq_full, rxq_empty, rxq_full;

   // sideband requests only use cycles free of host writes
   assign tx_serve = !host_we && tx_req && !tx_ack_q && !txq_empty;
   assign rx_serve = !host_we && !tx_serve && rx_req && !rx_ack_q;

   // ---------------- pool ----------------
   logic          rel_en, alloc_en, alloc_ok, pool_full, pool_clear, retry;
   logic [IW-1:0] rel_idx, alloc_idx;

   always_comb begin
      rel_en  = 1'b0;
      rel_idx = '0;
      if (host_cmd && op == OP_RX_FREE && !rxq_empty) begin
         rel_en  = 1'b1;
         rel_idx = rxq_h;
      end else if (host_cmd && op == OP_FREE_PNUM) begin
         rel_en  = 1'b1;
         rel_idx = pnum_q[IW-1:0];
      end else if (tx_serve && auto_release) begin
         rel_en  = 1'b1;
         rel_idx = txq_h;
      end
   end

   assign pool_clear = host_cmd && op == OP_RESET;
   assign retry      = rel_en && txres_q == NONE_CODE;
   assign alloc_en   = (host_cmd && op == OP_TX_ALLOC) || retry || rx_serve;

   pbuf_pool #(.NUM_BUFS(NUM_BUFS)) u_pool (
      .clk(clk), .rst_n(rst_n), .clear(pool_clear),
      .rel_en(rel_en), .rel_idx(rel_idx), .alloc_en(alloc_en),
      .alloc_ok(alloc_ok), .alloc_idx(alloc_idx),
      .full(pool_full), .count(alloc_count)
   );

   // ---------------- lists ----------------
   logic tx_clear;
   assign tx_clear = host_cmd && (op == OP_RESET || op == OP_TX_FLUSH);

   pbuf_queue #(.DEPTH(NUM_BUFS), .W(IW)) u_txq (
      .clk(clk), .rst_n(rst_n), .clear(tx_clear),
      .push(host_cmd && op == OP_TX_QUEUE && !txq_full),
      .pop(tx_serve), .din(pnum_q[IW-1:0]),
      .head(txq_h), .count(txq_cnt), .count_next(txq_nxt),
      .empty(txq_empty), .full(txq_full)
   );

   pbuf_queue #(.DEPTH(NUM_BUFS), .W(IW)) u_doneq (
      .clk(clk), .rst_n(rst_n), .clear(tx_clear),
      .push(tx_serve && !auto_release && !dq_full),
      .pop(host_ack && host_wdata[IRQ_TXDONE]), .din(txq_h),
      .head(dq_h), .count(dq_cnt), .count_next(dq_nxt),
      .empty(dq_empty), .full(dq_full)
   );

   pbuf_queue #(.DEPTH(NUM_BUFS), .W(IW)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clear(pool_clear),
      .push(rx_serve && alloc_ok && !rxq_full),
      .pop(host_cmd && (op == OP_RX_DROP || op == OP_RX_FREE)), .din(alloc_idx),
      .head(rxq_h), .count(rxq_cnt), .count_next(rxq_nxt),
      .empty(rxq_empty), .full(rxq_full)
   );

   // ---------------- interrupt level ----------------
   always_comb begin
      lvl_d = lvl_q;
      if (host_ack) lvl_d = lvl_d & ~(host_wdata & ACK_CLEARABLE);
      if (host_cmd && op == OP_TX_ALLOC) lvl_d[IRQ_ALLOC] = alloc_ok;
      if (retry && alloc_ok) lvl_d[IRQ_ALLOC] = 1'b1;
      if (host_cmd && (op == OP_RX_DROP || op == OP_RX_FREE))
         lvl_d[IRQ_RCV] = (rxq_cnt > ONE_C);
      if (rx_serve && alloc_ok) lvl_d[IRQ_RCV] = 1'b1;
      if (txq_nxt == '0) lvl_d[IRQ_TXEMPTY] = 1'b1;
      if (dq_nxt != '0)  lvl_d[IRQ_TXDONE]  = 1'b1;
   end

   // ---------------- registers ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         txres_q   <= '0;
         pnum_q    <= '0;
         lvl_q     <= LEVEL_RESET;
         imask_q   <= '0;
         tx_ack_q  <= 1'b0;
         rx_ack_q  <= 1'b0;
         rx_fail_q <= 1'b0;
         rx_num_q  <= NONE_CODE;
      end else begin
         lvl_q    <= lvl_d;
         tx_ack_q <= tx_serve;
         rx_ack_q <= rx_serve;
         if (host_pnum) pnum_q  <= host_wdata;
         if (host_mask) imask_q <= host_wdata;
         if (pool_clear)
            txres_q <= '0;
         else if (host_cmd && op == OP_TX_ALLOC)
            txres_q <= alloc_ok ? widen(alloc_idx) : NONE_CODE;
         else if (retry && alloc_ok)
            txres_q <= widen(alloc_idx);
         if (rx_serve) begin
            rx_fail_q <= !alloc_ok;
            rx_num_q  <= alloc_ok ? widen(alloc_idx) : NONE_CODE;
         end
      end
   end

   assign tx_ack    = tx_ack_q;
   assign rx_ack    = rx_ack_q;
   assign rx_fail   = rx_fail_q;
   assign rx_num    = rx_num_q;
   assign tx_result = txres_q;
   assign pkt_num   = pnum_q;
   assign txq_valid = !txq_empty;
   assign txq_num   = widen(txq_h);
   assign done_head = dq_empty  ? NONE_CODE : widen(dq_h);
   assign rx_head   = rxq_empty ? NONE_CODE : widen(rxq_h);
   assign pool_size = CW'(NUM_BUFS);
   assign irq_level = lvl_q;
   assign irq_mask  = imask_q;
   assign irq       = |(lvl_q & imask_q);

   // ---------------- assertions ----------------
   assert_txempty_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (txq_cnt == '0) |-> irq_level[IRQ_TXEMPTY]);

   assert_done_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_cnt != '0) |-> irq_level[IRQ_TXDONE]);

   assert_pending_only_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_result == NONE_CODE) |-> pool_full);

   assert_side_deferred_R12: assert property (@(posedge clk) disable iff (!rst_n)
      host_we |=> !(tx_ack || rx_ack));

   assert_rx_grant_rcv_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ack && !rx_fail) |-> irq_level[IRQ_RCV]);

   assert_rcv_clears_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_cmd && (op == OP_RX_DROP || op == OP_RX_FREE) && rxq_cnt <= ONE_C)
      |=> !irq_level[IRQ_RCV]);

   assert_ack_keeps_alloc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack |=> irq_level[IRQ_ALLOC] == $past(irq_level[IRQ_ALLOC]));

endmodule

// File: tb/pbuf_alloc_unit_tb.sv
`timescale 1ns/1ps
module pbuf_alloc_unit_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_we = 1'b0;
   logic [1:0] host_sel = 2'd0;
   logic [7:0] host_wdata = 8'd0;
   logic       auto_release = 1'b0;
   logic       tx_req = 1'b0;
   logic       rx_req = 1'b0;
   logic       tx_ack, txq_valid, rx_ack, rx_fail, irq;
   logic [7:0] txq_num, rx_num, tx_result, pkt_num, done_head, rx_head, irq_level, irq_mask;
   logic [2:0] alloc_count, pool_size;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   pbuf_alloc_unit u_dut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata), .auto_release(auto_release),
      .tx_req(tx_req), .tx_ack(tx_ack), .txq_valid(txq_valid), .txq_num(txq_num),
      .rx_req(rx_req), .rx_ack(rx_ack), .rx_fail(rx_fail), .rx_num(rx_num),
      .tx_result(tx_result), .pkt_num(pkt_num), .done_head(done_head),
      .rx_head(rx_head), .alloc_count(alloc_count), .pool_size(pool_size),
      .irq_level(irq_level), .irq_mask(irq_mask), .irq(irq)
   );

   localparam logic [1:0] S_CMD = 2'd0, S_PNUM = 2'd1, S_ACK = 2'd2, S_MASK = 2'd3;

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic hw(input logic [1:0] sel, input logic [7:0] d);
      host_we = 1'b1; host_sel = sel; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
      @(negedge clk);
   endtask

   task automatic cmd(input int op);
      hw(S_CMD, 8'(op << 5));
   endtask

   task automatic serve_tx(input string req);
      bit got = 0;
      tx_req = 1'b1;
      for (int k = 0; k < 10 && !got; k++) begin
         @(negedge clk);
         if (tx_ack) got = 1;
      end
      tx_req = 1'b0;
      @(negedge clk);
      chk(req, int'(got), 1);
   endtask

   task automatic serve_rx(output int num, output int fail);
      bit got = 0;
      num = 0; fail = 0;
      rx_req = 1'b1;
      for (int k = 0; k < 10 && !got; k++) begin
         @(negedge clk);
         if (rx_ack) begin got = 1; num = rx_num; fail = rx_fail; end
      end
      rx_req = 1'b0;
      @(negedge clk);
      if (!got) chk("R7 rx handshake", 0, 1);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int num, fail;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R5 / R13 reset state
      chk("R1 tx_result", tx_result, 0);
      chk("R1 level", irq_level, 8'h04);
      chk("R1 mask", irq_mask, 0);
      chk("R1 irq", irq, 0);
      chk("R1 txq_valid", txq_valid, 0);
      chk("R5 done_head empty", done_head, 8'h80);
      chk("R5 rx_head empty", rx_head, 8'h80);
      chk("R13 count", alloc_count, 0);
      chk("R13 pool_size", pool_size, 4);

      // R2 / R3 allocation sweep: i-th allocation gets index i, fifth fails
      for (int i = 0; i < 5; i++) begin
         cmd(1);
         chk(i < 4 ? "R2 alloc index" : "R3 alloc full", tx_result, i < 4 ? i : 8'h80);
         chk(i < 4 ? "R2 alloc bit" : "R3 alloc bit", irq_level[3], i < 4 ? 1 : 0);
         chk("R13 count", alloc_count, i < 4 ? i + 1 : 4);
      end

      // R4 / R14 pending retry lands on every freed index
      for (int k = 0; k < 4; k++) begin
         cmd(1);
         chk("R3 full again", tx_result, 8'h80);
         hw(S_PNUM, 8'(k));
         chk("R14 pkt_num", pkt_num, k);
         cmd(5);
         chk("R4 retry index", tx_result, k);
         chk("R4 alloc bit", irq_level[3], 1);
         chk("R14 count stays full", alloc_count, 4);
      end

      // R11 unit reset
      cmd(2);
      chk("R11 count", alloc_count, 0);
      chk("R11 tx_result", tx_result, 0);

      // R6 transmit path, sent list kept
      cmd(1); chk("R2 alloc 0", tx_result, 0);
      cmd(1); chk("R2 alloc 1", tx_result, 1);
      hw(S_PNUM, 8'd0); cmd(6);
      hw(S_PNUM, 8'd1); cmd(6);
      chk("R6 txq_valid", txq_valid, 1);
      chk("R6 txq head", txq_num, 0);
      hw(S_ACK, 8'h04);
      chk("R10 ack txempty while busy", irq_level[2], 0);
      serve_tx("R6 tx handshake");
      chk("R6 txq next head", txq_num, 1);
      chk("R6 done head", done_head, 0);
      chk("R9 done bit", irq_level[1], 1);
      serve_tx("R6 tx handshake");
      chk("R6 done head fifo", done_head, 0);
      chk("R6 txq empty", txq_valid, 0);
      chk("R9 txempty bit", irq_level[2], 1);
      hw(S_MASK, 8'h02);
      chk("R9 irq on", irq, 1);
      hw(S_MASK, 8'h10);
      chk("R9 irq off", irq, 0);
      hw(S_ACK, 8'h02);
      chk("R10 pop done", done_head, 1);
      chk("R10 done bit held", irq_level[1], 1);
      hw(S_ACK, 8'h02);
      chk("R10 done empty", done_head, 8'h80);
      chk("R10 done bit cleared", irq_level[1], 0);
      chk("R6 buffers kept", alloc_count, 2);
      hw(S_ACK, 8'hFF);
      chk("R10 ack all", irq_level, 8'h0C);

      // R6 auto release
      auto_release = 1'b1;
      hw(S_PNUM, 8'd0); cmd(6);
      serve_tx("R6 tx handshake");
      chk("R6 auto release count", alloc_count, 1);
      chk("R6 auto release no done", done_head, 8'h80);
      auto_release = 1'b0;

      // R7 receive allocation sweep
      cmd(2);
      for (int i = 0; i < 5; i++) begin
         serve_rx(num, fail);
         chk("R7 rx fail", fail, i < 4 ? 0 : 1);
         chk("R7 rx num", num, i < 4 ? i : 8'h80);
      end
      chk("R7 count", alloc_count, 4);
      chk("R7 rx head", rx_head, 0);
      chk("R7 rcv bit", irq_level[0], 1);

      // R8 receive pops
      cmd(3);
      chk("R8 drop head", rx_head, 1);
      chk("R8 drop keeps buffer", alloc_count, 4);
      chk("R8 rcv held", irq_level[0], 1);
      for (int i = 0; i < 3; i++) begin
         cmd(4);
         chk("R8 free head", rx_head, i < 2 ? i + 2 : 8'h80);
         chk("R8 free count", alloc_count, 3 - i);
         chk("R8 rcv bit", irq_level[0], i < 2 ? 1 : 0);
      end

      // R12 host write and receive request in the same cycle
      rx_req = 1'b1;
      host_we = 1'b1; host_sel = S_PNUM; host_wdata = 8'd3;
      @(negedge clk);
      host_we = 1'b0;
      chk("R12 rx deferred", rx_ack, 0);
      chk("R12 host served", pkt_num, 3);
      @(negedge clk);
      chk("R12 rx served", rx_ack, 1);
      chk("R12 rx num", rx_num, 1);
      rx_req = 1'b0;
      @(negedge clk);

      // R11 flush of transmit lists keeps the receive list
      cmd(1); chk("R2 alloc 2", tx_result, 2);
      hw(S_PNUM, 8'd2); cmd(6);
      chk("R6 queued", txq_valid, 1);
      cmd(7);
      chk("R11 flush txq", txq_valid, 0);
      chk("R11 flush done", done_head, 8'h80);
      chk("R11 rx kept", rx_head, 1);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule